// File: doc/BRIEF.md
# GPIO Function Select and Override Mux

This block sits between a bank of general-purpose pads and the on-chip peripherals. Every pin stores a five-bit function code that chooses which of ten peripheral functions owns it. The pad output and output enable come from that peripheral's signals. The pad input value goes back to that peripheral's input. Each function offers four lanes, and a pin always connects to lane `pin mod 4` of whichever function it selects.

After selection, four independent two-bit overrides act on each pin: one on the output value, one on the output enable, one on the input value seen by peripherals, and one on the interrupt signal taken from the raw pad input. Each override can pass the signal, invert it, force it low or force it high. When several pins select the same function lane, that lane receives the OR of their (overridden) input values. Pad electrical settings (pull-up, pull-down, slew, drive strength) are stored per pin and presented as static outputs.

Software configures the block through a one-cycle write port. Reads are combinational. Address bit 0 selects the register kind: 0 is the control register and 1 is the pad register. The bits above it are the pin number.

Top module: `gpio_fsel_mux`

## Requirements
- R1: After reset, every control register reads 0x001F (null function, all overrides pass) and every pad register reads 0x0008 (drive code 1, all else 0). No pad is output-enabled, every pad output is low, and every peripheral input lane is 0.
- R2: The control register layout is function code [4:0], output override [6:5], output-enable override [8:7], input override [10:9] and interrupt override [12:11]. Function codes 0 to 9 are supported. With a supported code f and pass overrides, pin p drives `pad_out_o[p] = fn_out_i[f*4 + p%4]` and `pad_oe_o[p] = fn_oe_i[f*4 + p%4]`.
- R3: Code 0x1F (null) and any unsupported code (10 to 30) leave the pin unconnected. With pass overrides, the pad output and output enable are 0 and the pin feeds no peripheral lane. The register still reads back the exact stored code.
- R4: The output override applies after selection. Code 0 passes the value, 1 inverts it, 2 forces 0 and 3 forces 1.
- R5: The output-enable override uses the same four codes on the selected enable. Codes 2 and 3 force the enable off and on, even on a null pin.
- R6: The input override, with the same four codes, is applied to the pad input before it reaches the selected peripheral lane.
- R7: Peripheral lane `f*4+l` equals the OR of the overridden inputs of every pin with function f and `p%4 == l`. A lane no pin selects reads 0.
- R8: `irq_o[p]` is the interrupt override (same four codes) applied to the raw pad input, independent of the function code.
- R9: The pad register layout is pull-up [0], pull-down [1], fast slew [2] and drive [4:3]. Pull-up alone asserts only `pad_pu_o`. Pull-down alone asserts only `pad_pd_o`. Both set asserts only `pad_keep_o`. Slew and drive appear unchanged on their outputs.
- R10: Writes whose pin number is 30 or above change nothing, and reads of such addresses return 0.
- R11: A write takes effect at the next rising clock edge. The readback path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {pin, kind} |
| wr_data | input | 13 | Write data |
| rd_addr | input | 6 | Read address {pin, kind} |
| rd_data | output | 13 | Combinational read data |
| fn_out_i | input | 40 | Peripheral output values, function-major, 4 lanes each |
| fn_oe_i | input | 40 | Peripheral output enables, same order |
| fn_in_o | output | 40 | Merged peripheral input lanes, same order |
| pad_in_i | input | 30 | Raw pad input levels |
| pad_out_o | output | 30 | Pad output values |
| pad_oe_o | output | 30 | Pad output enables |
| irq_o | output | 30 | Per-pin interrupt signals |
| pad_pu_o | output | 30 | Pull-up active |
| pad_pd_o | output | 30 | Pull-down active |
| pad_keep_o | output | 30 | Bus-keep active |
| pad_slew_fast_o | output | 30 | Fast slew selected |
| pad_drive_o | output | 60 | Drive strength code, two bits per pin |

## Verification
The only state is the stored configuration, so a corrupted field shows up one cycle after the write that should have set it. It appears as a wrong readback and, in the same cycle, as the wrong peripheral lane on a pad, a stray output enable, or an input routed into the wrong lane of `fn_in_o`. Sweeping every function code on every pin, and every override code against both input polarities, exposes a mis-decoded field within one write. A merge error is visible only when two pins share a lane, so the input sweep places pins on shared lanes on purpose.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int FSEL_W    = 5;
    localparam int OVR_W     = 2;
    localparam int CTRL_W    = FSEL_W + 4 * OVR_W;
    localparam int PAD_W     = 5;

    // control register field positions
    localparam int FSEL_LSB  = 0;
    localparam int OOUT_LSB  = FSEL_LSB + FSEL_W;
    localparam int OOE_LSB   = OOUT_LSB + OVR_W;
    localparam int OIN_LSB   = OOE_LSB + OVR_W;
    localparam int OIRQ_LSB  = OIN_LSB + OVR_W;

    // pad register field positions
    localparam int PU_BIT    = 0;
    localparam int PD_BIT    = 1;
    localparam int SLEW_BIT  = 2;
    localparam int DRV_LSB   = 3;

    localparam logic [FSEL_W-1:0] FSEL_NULL = 5'h1F;
    localparam logic [CTRL_W-1:0] CTRL_RST  = CTRL_W'(FSEL_NULL);
    localparam logic [PAD_W-1:0]  PAD_RST   = 5'b01000;

    typedef enum logic [OVR_W-1:0] {
        OVR_PASS = 2'd0,
        OVR_INV  = 2'd1,
        OVR_LOW  = 2'd2,
        OVR_HIGH = 2'd3
    } ovr_e;

    function automatic logic apply_ovr(input ovr_e mode, input logic val);
        logic res;
        unique case (mode)
            OVR_PASS: res = val;
            OVR_INV:  res = ~val;
            OVR_LOW:  res = 1'b0;
            OVR_HIGH: res = 1'b1;
            default:  res = val;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 30,
    parameter int PIN_W    = $clog2(NUM_PINS),
    parameter int ADDR_W   = PIN_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [CTRL_W-1:0]                  wr_data,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [CTRL_W-1:0]                  rd_data,
    output logic [NUM_PINS-1:0][CTRL_W-1:0]    ctrl_q,
    output logic [NUM_PINS-1:0][PAD_W-1:0]     pad_q
);

    logic [PIN_W-1:0] wr_pin;
    logic [PIN_W-1:0] rd_pin;
    logic             wr_hit;
    logic             rd_hit;

    assign wr_pin = wr_addr[ADDR_W-1:1];
    assign rd_pin = rd_addr[ADDR_W-1:1];
    assign wr_hit = wr_en && (int'(wr_pin) < NUM_PINS);
    assign rd_hit = int'(rd_pin) < NUM_PINS;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                ctrl_q[p] <= CTRL_RST;
                pad_q[p]  <= PAD_RST;
            end
        end else if (wr_hit) begin
            if (wr_addr[0]) begin
                pad_q[wr_pin] <= wr_data[PAD_W-1:0];
            end else begin
                ctrl_q[wr_pin] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            if (rd_addr[0]) begin
                rd_data = CTRL_W'(pad_q[rd_pin]);
            end else begin
                rd_data = ctrl_q[rd_pin];
            end
        end
    end

endmodule

// File: rtl/gpio_pin_path.sv
module gpio_pin_path
    import gpio_mux_pkg::*;
#(
    parameter int NUM_FUNCS = 10
) (
    input  logic [FSEL_W-1:0]    fsel,
    input  logic [OVR_W-1:0]     out_ovr,
    input  logic [OVR_W-1:0]     oe_ovr,
    input  logic [OVR_W-1:0]     in_ovr,
    input  logic [OVR_W-1:0]     irq_ovr,
    input  logic [NUM_FUNCS-1:0] fn_out,
    input  logic [NUM_FUNCS-1:0] fn_oe,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 in_val,
    output logic                 irq
);

    logic sel_out;
    logic sel_oe;

    // one-hot style pick keeps the index inside the supported range
    always_comb begin
        sel_out = 1'b0;
        sel_oe  = 1'b0;
        for (int f = 0; f < NUM_FUNCS; f++) begin
            if (fsel == FSEL_W'(f)) begin
                sel_out = fn_out[f];
                sel_oe  = fn_oe[f];
            end
        end
    end

    always_comb begin
        pad_out = apply_ovr(ovr_e'(out_ovr), sel_out);
        pad_oe  = apply_ovr(ovr_e'(oe_ovr), sel_oe);
        in_val  = apply_ovr(ovr_e'(in_ovr), pad_in);
        irq     = apply_ovr(ovr_e'(irq_ovr), pad_in);
    end

endmodule

// File: rtl/gpio_in_merge.sv
module gpio_in_merge
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 30,
    parameter int NUM_FUNCS = 10,
    parameter int NUM_LANES = 4,
    parameter int LANE_BITS = NUM_FUNCS * NUM_LANES
) (
    input  logic [NUM_PINS-1:0][FSEL_W-1:0] fsel,
    input  logic [NUM_PINS-1:0]             in_val,
    output logic [LANE_BITS-1:0]            fn_in
);

    always_comb begin
        fn_in = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int f = 0; f < NUM_FUNCS; f++) begin
                if (fsel[p] == FSEL_W'(f)) begin
                    fn_in[f * NUM_LANES + (p % NUM_LANES)] |= in_val[p];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_fsel_mux.sv
module gpio_fsel_mux
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 30,
    parameter int NUM_FUNCS = 10,
    parameter int NUM_LANES = 4,
    parameter int PIN_W     = $clog2(NUM_PINS),
    parameter int ADDR_W    = PIN_W + 1,
    parameter int LANE_BITS = NUM_FUNCS * NUM_LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CTRL_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [CTRL_W-1:0]      rd_data,
    input  logic [LANE_BITS-1:0]   fn_out_i,
    input  logic [LANE_BITS-1:0]   fn_oe_i,
    output logic [LANE_BITS-1:0]   fn_in_o,
    input  logic [NUM_PINS-1:0]    pad_in_i,
    output logic [NUM_PINS-1:0]    pad_out_o,
    output logic [NUM_PINS-1:0]    pad_oe_o,
    output logic [NUM_PINS-1:0]    irq_o,
    output logic [NUM_PINS-1:0]    pad_pu_o,
    output logic [NUM_PINS-1:0]    pad_pd_o,
    output logic [NUM_PINS-1:0]    pad_keep_o,
    output logic [NUM_PINS-1:0]    pad_slew_fast_o,
    output logic [2*NUM_PINS-1:0]  pad_drive_o
);

    logic [NUM_PINS-1:0][CTRL_W-1:0] ctrl_q;
    logic [NUM_PINS-1:0][PAD_W-1:0]  pad_q;
    logic [NUM_PINS-1:0][FSEL_W-1:0] fsel;
    logic [NUM_PINS-1:0][OVR_W-1:0]  out_ovr;
    logic [NUM_PINS-1:0][OVR_W-1:0]  oe_ovr;
    logic [NUM_PINS-1:0][OVR_W-1:0]  in_ovr;
    logic [NUM_PINS-1:0][OVR_W-1:0]  irq_ovr;
    logic [NUM_PINS-1:0]             in_val;
    logic [NUM_PINS-1:0]             pin_in;

    gpio_cfg_regs #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W),
        .ADDR_W   (ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .pad_q   (pad_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int LANE = p % NUM_LANES;

        logic [NUM_FUNCS-1:0] lane_out;
        logic [NUM_FUNCS-1:0] lane_oe;
        logic                 pu;
        logic                 pd;

        assign fsel[p]    = ctrl_q[p][FSEL_LSB +: FSEL_W];
        assign out_ovr[p] = ctrl_q[p][OOUT_LSB +: OVR_W];
        assign oe_ovr[p]  = ctrl_q[p][OOE_LSB  +: OVR_W];
        assign in_ovr[p]  = ctrl_q[p][OIN_LSB  +: OVR_W];
        assign irq_ovr[p] = ctrl_q[p][OIRQ_LSB +: OVR_W];

        for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
            assign lane_out[f] = fn_out_i[f * NUM_LANES + LANE];
            assign lane_oe[f]  = fn_oe_i[f * NUM_LANES + LANE];
        end

        gpio_pin_path #(
            .NUM_FUNCS (NUM_FUNCS)
        ) path_i (
            .fsel    (fsel[p]),
            .out_ovr (out_ovr[p]),
            .oe_ovr  (oe_ovr[p]),
            .in_ovr  (in_ovr[p]),
            .irq_ovr (irq_ovr[p]),
            .fn_out  (lane_out),
            .fn_oe   (lane_oe),
            .pad_in  (pad_in_i[p]),
            .pad_out (pad_out_o[p]),
            .pad_oe  (pad_oe_o[p]),
            .in_val  (pin_in[p]),
            .irq     (irq_o[p])
        );

        assign in_val[p] = pin_in[p];

        // pad settings: both pulls requested means keeper only
        assign pu                       = pad_q[p][PU_BIT];
        assign pd                       = pad_q[p][PD_BIT];
        assign pad_pu_o[p]              = pu & ~pd;
        assign pad_pd_o[p]              = pd & ~pu;
        assign pad_keep_o[p]            = pu & pd;
        assign pad_slew_fast_o[p]       = pad_q[p][SLEW_BIT];
        assign pad_drive_o[2*p +: 2]    = pad_q[p][DRV_LSB +: 2];
    end

    gpio_in_merge #(
        .NUM_PINS  (NUM_PINS),
        .NUM_FUNCS (NUM_FUNCS),
        .NUM_LANES (NUM_LANES),
        .LANE_BITS (LANE_BITS)
    ) merge_i (
        .fsel   (fsel),
        .in_val (in_val),
        .fn_in  (fn_in_o)
    );

endmodule

// File: rtl/gpio_fsel_mux_chk.sv
module gpio_fsel_mux_chk
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS  = 30,
    parameter int NUM_FUNCS = 10,
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = 6,
    parameter int LANE_BITS = NUM_FUNCS * NUM_LANES
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [NUM_PINS-1:0][FSEL_W-1:0]  fsel,
    input logic [NUM_PINS-1:0][OVR_W-1:0]   oe_ovr,
    input logic [NUM_PINS-1:0][OVR_W-1:0]   irq_ovr,
    input logic [NUM_PINS-1:0]              pad_in,
    input logic [NUM_PINS-1:0]              pad_oe,
    input logic [NUM_PINS-1:0]              irq,
    input logic [LANE_BITS-1:0]             fn_in,
    input logic [NUM_PINS-1:0]              pad_pu,
    input logic [NUM_PINS-1:0]              pad_pd,
    input logic [NUM_PINS-1:0]              pad_keep
);

    logic [NUM_FUNCS-1:0] fn_used;

    always_comb begin
        fn_used = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            for (int f = 0; f < NUM_FUNCS; f++) begin
                if (fsel[p] == FSEL_W'(f)) fn_used[f] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        p_null_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(fsel[p]) >= NUM_FUNCS && oe_ovr[p] == 2'd0) |-> !pad_oe[p]);
        p_oe_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_ovr[p] == 2'd3) |-> pad_oe[p]);
        p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_ovr[p] == 2'd2) |-> !pad_oe[p]);
        p_irq_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ovr[p] == 2'd0) |-> (irq[p] == pad_in[p]));
        p_keep_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pad_keep[p] |-> (!pad_pu[p] && !pad_pd[p]));
    end

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        p_idle_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !fn_used[f] |-> (fn_in[f*NUM_LANES +: NUM_LANES] == '0));
    end

    p_oor_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr[ADDR_W-1:1]) >= NUM_PINS) |=> $stable(fsel));

endmodule

bind gpio_fsel_mux gpio_fsel_mux_chk #(
    .NUM_PINS  (NUM_PINS),
    .NUM_FUNCS (NUM_FUNCS),
    .NUM_LANES (NUM_LANES),
    .ADDR_W    (ADDR_W),
    .LANE_BITS (LANE_BITS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .fsel     (fsel),
    .oe_ovr   (oe_ovr),
    .irq_ovr  (irq_ovr),
    .pad_in   (pad_in_i),
    .pad_oe   (pad_oe_o),
    .irq      (irq_o),
    .fn_in    (fn_in_o),
    .pad_pu   (pad_pu_o),
    .pad_pd   (pad_pd_o),
    .pad_keep (pad_keep_o)
);

// File: tb/gpio_fsel_mux_tb_top.sv
`timescale 1ns/1ps
module gpio_fsel_mux_tb_top;

    localparam int NP = 30;
    localparam int NF = 10;
    localparam int NL = 4;
    localparam int AW = 6;
    localparam int DW = 13;
    localparam int LB = NF * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [LB-1:0] fn_out_i = '0;
    logic [LB-1:0] fn_oe_i = '0;
    logic [LB-1:0] fn_in_o;
    logic [NP-1:0] pad_in_i = '0;
    logic [NP-1:0] pad_out_o, pad_oe_o, irq_o;
    logic [NP-1:0] pad_pu_o, pad_pd_o, pad_keep_o, pad_slew_fast_o;
    logic [2*NP-1:0] pad_drive_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [DW-1:0] model_ctrl [NP];

    always #10 clk = ~clk;

    gpio_fsel_mux dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fn_out_i(fn_out_i), .fn_oe_i(fn_oe_i), .fn_in_o(fn_in_o),
        .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
        .irq_o(irq_o), .pad_pu_o(pad_pu_o), .pad_pd_o(pad_pd_o),
        .pad_keep_o(pad_keep_o), .pad_slew_fast_o(pad_slew_fast_o),
        .pad_drive_o(pad_drive_o)
    );

    function automatic logic bov(input int m, input logic v);
        case (m)
            0: return v;
            1: return ~v;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int sel_of(input int p);
        return (p < 25) ? (p % 10) : 12;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        if ((addr >> 1) < NP && (addr % 2) == 0) model_ctrl[addr >> 1] = data;
        #1;
    endtask

    task automatic rd(input int addr, output logic [DW-1:0] val);
        rd_addr = AW'(addr);
        #1;
        val = rd_data;
    endtask

    function automatic logic [DW-1:0] mk_ctrl(input int fs, input int oo,
                                              input int oe, input int ii, input int iq);
        return DW'((iq << 11) | (ii << 9) | (oe << 7) | (oo << 5) | fs);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [LB-1:0] pa, pb, expv;
        logic [NP-1:0] expi;
        int sels [14];

        for (int p = 0; p < NP; p++) model_ctrl[p] = 13'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        for (int p = 0; p < NP; p++) begin
            rd(2*p, v);   chk("R1 ctrl reset", v, 13'h1F);
            rd(2*p+1, v); chk("R1 pad reset", v, 13'h08);
        end
        fn_out_i = '1; fn_oe_i = '1; pad_in_i = '1; #1;
        chk("R1 oe low", pad_oe_o, 0);
        chk("R1 out low", pad_out_o, 0);
        chk("R1 lanes zero", fn_in_o, 0);

        // R2 R3 R11: every pin against supported, unsupported and null codes
        for (int i = 0; i < 10; i++) sels[i] = i;
        sels[10] = 10; sels[11] = 17; sels[12] = 30; sels[13] = 31;
        for (int k = 0; k < 2; k++) begin
            pa = 40'hA5_3C_96_F0_1E ^ {LB{k[0]}};
            pb = 40'h5A_C3_6B_0F_E2 ^ {LB{k[0]}};
            fn_out_i = pa; fn_oe_i = pb;
            for (int p = 0; p < NP; p++) begin
                for (int j = 0; j < 14; j++) begin
                    int s;
                    s = sels[j];
                    wr(2*p, DW'(s));
                    rd(2*p, v);
                    chk("R3 R11 readback", v, DW'(s));
                    if (s < NF) begin
                        chk("R2 out select", pad_out_o[p], pa[s*NL + p%NL]);
                        chk("R2 oe select", pad_oe_o[p], pb[s*NL + p%NL]);
                    end else begin
                        chk("R3 null out", pad_out_o[p], 0);
                        chk("R3 null oe", pad_oe_o[p], 0);
                    end
                end
                wr(2*p, 13'h1F);
            end
        end

        // R4 R5: override sweep on pin 7 (function 5, lane 3)
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 4; n++) begin
                wr(14, mk_ctrl(5, m, n, 0, 0));
                for (int b = 0; b < 2; b++) begin
                    fn_out_i = '0; fn_oe_i = '0;
                    fn_out_i[5*NL+3] = b[0];
                    fn_oe_i[5*NL+3]  = ~b[0];
                    #1;
                    chk("R4 out override", pad_out_o[7], bov(m, b[0]));
                    chk("R5 oe override", pad_oe_o[7], bov(n, ~b[0]));
                end
            end
        end
        wr(14, 13'h1F);
        wr(16, mk_ctrl(31, 3, 3, 0, 0));
        chk("R5 null forced oe", pad_oe_o[8], 1);
        chk("R4 null forced out", pad_out_o[8], 1);
        wr(16, 13'h1F);

        // R6 R7 R8: shared lanes, input and interrupt overrides
        for (int p = 0; p < NP; p++)
            wr(2*p, mk_ctrl(sel_of(p), 0, 0, (p >> 2) % 4, (p >> 1) % 4));
        for (int t = 0; t < 10; t++) begin
            pad_in_i = NP'(32'h2B7E_1516 * (t + 1) ^ (t * 32'h0101_0101));
            if (t == 0) pad_in_i = '0;
            if (t == 1) pad_in_i = '1;
            #1;
            expv = '0; expi = '0;
            for (int p = 0; p < NP; p++) begin
                int s;
                s = sel_of(p);
                if (s < NF) expv[s*NL + p%NL] |= bov((p >> 2) % 4, pad_in_i[p]);
                expi[p] = bov((p >> 1) % 4, pad_in_i[p]);
            end
            chk("R6 R7 merged lanes", fn_in_o, expv);
            chk("R8 irq", irq_o, expi);
        end
        // R7: pins 0 and 20 share function 0 lane 0, pass override needed
        wr(0, mk_ctrl(0, 0, 0, 0, 0));
        wr(40, mk_ctrl(0, 0, 0, 0, 0));
        wr(20, mk_ctrl(31, 0, 0, 0, 0));
        pad_in_i = '0; pad_in_i[20] = 1'b1; #1;
        chk("R7 or from second pin", fn_in_o[0], 1);
        pad_in_i = '0; pad_in_i[0] = 1'b1; #1;
        chk("R7 or from first pin", fn_in_o[0], 1);
        pad_in_i = '0; #1;
        chk("R7 or none high", fn_in_o[0], 0);

        // R9: pad register decode on pin 3
        for (int x = 0; x < 32; x++) begin
            wr(7, DW'(x));
            rd(7, v);
            chk("R9 pad readback", v, DW'(x));
            chk("R9 pull up", pad_pu_o[3], x[0] & ~x[1]);
            chk("R9 pull down", pad_pd_o[3], x[1] & ~x[0]);
            chk("R9 keep", pad_keep_o[3], x[0] & x[1]);
            chk("R9 slew", pad_slew_fast_o[3], x[2]);
            chk("R9 drive", pad_drive_o[7:6], x[4:3]);
        end

        // R10: out-of-range pins
        for (int a = 60; a < 64; a++) wr(a, 13'h0A5);
        for (int a = 60; a < 64; a++) begin
            rd(a, v);
            chk("R10 oor read zero", v, 0);
        end
        for (int p = 0; p < NP; p++) begin
            rd(2*p, v);
            chk("R10 ctrl untouched", v, model_ctrl[p]);
        end
        rd(7, v);
        chk("R10 pad untouched", v, 13'h1F);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule